// File: doc/BRIEF.md
# Bridge Fault Diagnostic Logic

This block turns the raw comparator results of a three-phase MOSFET gate driver into its diagnostic and protection outputs. Each phase supplies two drain-source over-threshold bits, one for the high-side transistor and one for the low-side transistor. The block also receives the actual gate states, the bridge enable, a bridge-open bit, and the supply and temperature comparator bits. It produces an active-low summary fault, two battery-level flags that can float, enables for the boost converter and the gate regulator, and a gate shutdown request.

A drain-source comparison only means something while the transistor it watches is switched on. For that reason, a per-phase result counts only when its gate is on and the bridge enable is high. Some faults are only reported: motor lead shorts, bridge open and regulator undervoltage. Others also act on the chip: battery undervoltage, logic-supply undervoltage and over-temperature switch both supplies off and request a gate shutdown. Battery overvoltage only stops the boost converter.

All inputs are registered once. Every output is a combinational function of that registered set, so a transient comparator pulse during switching appears for as long as it lasts and is never held.

Top module: `bridge_fault_diag`

## Requirements
- R1: Every output reflects the inputs sampled at the previous rising clock edge. While rst is high, and in the first cycle after it falls, the outputs read fault_n_o=1, both flags driven low with their enables at 1, boost_en_o=1, vreg_en_o=1 and gate_kill_o=0.
- R2: A short to ground is flagged (fault_n_o=0) when, for some phase p, enable_i=1, gate_hi_i[p]=1 and hs_ovth_i[p]=1.
- R3: A short to battery is flagged (fault_n_o=0) when, for some phase p, enable_i=1, gate_lo_i[p]=1 and ls_ovth_i[p]=1.
- R4: A drain-source bit whose gate is off, or any drain-source bit while enable_i=0, has no effect on any output.
- R5: drain_open_i=1 flags a fault when enable_i=1 and is ignored when enable_i=0.
- R6: Each of bat_ov_i, bat_uv_i, reg_uv_i, logic_uv_i and therm_i alone drives fault_n_o low, whatever the value of enable_i.
- R7: ov_flag_o follows bat_ov_i and uv_flag_o follows bat_uv_i. If both inputs are high, only uv_flag_o is raised, so the two flags are never high together.
- R8: When therm_i or logic_uv_i is high, both flags float: ov_oe_o=uv_oe_o=0 and the data bits read 0.
- R9: bat_uv_i, logic_uv_i or therm_i clears boost_en_o and vreg_en_o and sets gate_kill_o.
- R10: bat_ov_i alone clears boost_en_o, while vreg_en_o stays 1 and gate_kill_o stays 0.
- R11: reg_uv_i and the drain-source and bridge-open faults are report-only: boost_en_o=vreg_en_o=1 and gate_kill_o=0.
- R12: No fault is latched. fault_n_o returns to 1 one cycle after the last cause is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Bridge enable |
| gate_hi_i | input | NPH (3) | High-side gate on, per phase |
| gate_lo_i | input | NPH (3) | Low-side gate on, per phase |
| hs_ovth_i | input | NPH (3) | Drain-to-phase voltage above threshold |
| ls_ovth_i | input | NPH (3) | Phase-to-source voltage above threshold |
| drain_open_i | input | 1 | Bridge drain sense open |
| bat_ov_i | input | 1 | Battery overvoltage |
| bat_uv_i | input | 1 | Battery undervoltage |
| reg_uv_i | input | 1 | Gate regulator undervoltage |
| logic_uv_i | input | 1 | Logic supply undervoltage |
| therm_i | input | 1 | Thermal shutdown |
| fault_n_o | output | 1 | Summary fault, active low |
| ov_flag_o | output | 1 | Overvoltage flag data |
| ov_oe_o | output | 1 | Overvoltage flag drive enable (0 = high impedance) |
| uv_flag_o | output | 1 | Undervoltage flag data |
| uv_oe_o | output | 1 | Undervoltage flag drive enable (0 = high impedance) |
| boost_en_o | output | 1 | Boost converter enable |
| vreg_en_o | output | 1 | Gate regulator enable |
| gate_kill_o | output | 1 | Request to force all gates low |

## Verification
The bench sets an over-threshold bit on a phase whose gate is off, or on the wrong side of the phase. A design that ignored gate qualification would pull the fault low there. It repeats each per-phase short and the bridge-open case with enable low; a design that missed the enable gating would report faults during coast. It drives overvoltage and undervoltage together, and overvoltage together with over-temperature. A wrong priority would raise both flags at once, or drive a flag that should float. It also removes each cause and checks that the fault clears on the next cycle, which a latching design would fail.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

    typedef struct packed {
        logic bat_ov;
        logic bat_uv;
        logic reg_uv;
        logic logic_uv;
        logic therm;
    } supply_t;

    typedef struct packed {
        logic data;
        logic oe;
    } tri_flag_t;

    typedef enum logic [1:0] {
        SEV_NONE     = 2'd0,
        SEV_REPORT   = 2'd1,
        SEV_LIMIT    = 2'd2,
        SEV_SHUTDOWN = 2'd3
    } sev_e;

    typedef struct packed {
        tri_flag_t ov;
        tri_flag_t uv;
        logic      boost_en;
        logic      vreg_en;
        logic      gate_kill;
        logic      alarm;
    } supply_ctl_t;

    function automatic sev_e classify(supply_t s);
        if (s.bat_uv || s.logic_uv || s.therm) return SEV_SHUTDOWN;
        if (s.bat_ov)                          return SEV_LIMIT;
        if (s.reg_uv)                          return SEV_REPORT;
        return SEV_NONE;
    endfunction

    function automatic tri_flag_t drive_flag(logic hiz, logic level);
        tri_flag_t f;
        f.oe   = ~hiz;
        f.data = hiz ? 1'b0 : level;
        return f;
    endfunction

endpackage

// File: rtl/bfd_in_reg.sv
module bfd_in_reg
    import bfd_pkg::*;
#(
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_d,
    input  logic [NPH-1:0] gh_d,
    input  logic [NPH-1:0] gl_d,
    input  logic [NPH-1:0] hs_d,
    input  logic [NPH-1:0] ls_d,
    input  logic           open_d,
    input  supply_t        sup_d,
    output logic           en_q,
    output logic [NPH-1:0] gh_q,
    output logic [NPH-1:0] gl_q,
    output logic [NPH-1:0] hs_q,
    output logic [NPH-1:0] ls_q,
    output logic           open_q,
    output supply_t        sup_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            gh_q   <= '0;
            gl_q   <= '0;
            hs_q   <= '0;
            ls_q   <= '0;
            open_q <= 1'b0;
            sup_q  <= '0;
        end else begin
            en_q   <= en_d;
            gh_q   <= gh_d;
            gl_q   <= gl_d;
            hs_q   <= hs_d;
            ls_q   <= ls_d;
            open_q <= open_d;
            sup_q  <= sup_d;
        end
    end

endmodule

// File: rtl/bfd_phase_qual.sv
module bfd_phase_qual (
    input  logic en,
    input  logic gate_hi,
    input  logic gate_lo,
    input  logic hs_over,
    input  logic ls_over,
    input  logic bridge_open,
    output logic short_gnd,
    output logic short_bat
);

    // An open drain sense reads as a ground short on every phase.
    always_comb begin
        short_gnd = en & ((gate_hi & hs_over) | bridge_open);
        short_bat = en & gate_lo & ls_over;
    end

endmodule

// File: rtl/bfd_supply_ctl.sv
module bfd_supply_ctl
    import bfd_pkg::*;
(
    input  supply_t     sup,
    output supply_ctl_t ctl
);

    sev_e sev;
    logic hiz;

    always_comb begin
        sev = classify(sup);
        hiz = sup.therm | sup.logic_uv;
        // Undervoltage takes priority so the flags stay exclusive.
        ctl.ov        = drive_flag(hiz, sup.bat_ov & ~sup.bat_uv);
        ctl.uv        = drive_flag(hiz, sup.bat_uv);
        ctl.gate_kill = (sev == SEV_SHUTDOWN);
        ctl.vreg_en   = (sev != SEV_SHUTDOWN);
        ctl.boost_en  = (sev == SEV_NONE) || (sev == SEV_REPORT);
        ctl.alarm     = (sev != SEV_NONE);
    end

endmodule

// File: rtl/bridge_fault_diag.sv
module bridge_fault_diag
    import bfd_pkg::*;
#(
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable_i,
    input  logic [NPH-1:0] gate_hi_i,
    input  logic [NPH-1:0] gate_lo_i,
    input  logic [NPH-1:0] hs_ovth_i,
    input  logic [NPH-1:0] ls_ovth_i,
    input  logic           drain_open_i,
    input  logic           bat_ov_i,
    input  logic           bat_uv_i,
    input  logic           reg_uv_i,
    input  logic           logic_uv_i,
    input  logic           therm_i,
    output logic           fault_n_o,
    output logic           ov_flag_o,
    output logic           ov_oe_o,
    output logic           uv_flag_o,
    output logic           uv_oe_o,
    output logic           boost_en_o,
    output logic           vreg_en_o,
    output logic           gate_kill_o
);

    localparam int LAST = NPH - 1;

    supply_t        sup_d, sup_q;
    logic           en_q, open_q;
    logic [LAST:0]  gh_q, gl_q, hs_q, ls_q;
    logic [LAST:0]  stg, stb;
    supply_ctl_t    ctl;

    always_comb begin
        sup_d.bat_ov   = bat_ov_i;
        sup_d.bat_uv   = bat_uv_i;
        sup_d.reg_uv   = reg_uv_i;
        sup_d.logic_uv = logic_uv_i;
        sup_d.therm    = therm_i;
    end

    bfd_in_reg #(.NPH(NPH)) u_in (
        .clk(clk), .rst(rst),
        .en_d(enable_i), .gh_d(gate_hi_i), .gl_d(gate_lo_i),
        .hs_d(hs_ovth_i), .ls_d(ls_ovth_i), .open_d(drain_open_i),
        .sup_d(sup_d),
        .en_q(en_q), .gh_q(gh_q), .gl_q(gl_q),
        .hs_q(hs_q), .ls_q(ls_q), .open_q(open_q),
        .sup_q(sup_q)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        bfd_phase_qual u_q (
            .en(en_q), .gate_hi(gh_q[p]), .gate_lo(gl_q[p]),
            .hs_over(hs_q[p]), .ls_over(ls_q[p]), .bridge_open(open_q),
            .short_gnd(stg[p]), .short_bat(stb[p])
        );
    end

    bfd_supply_ctl u_sup (.sup(sup_q), .ctl(ctl));

    always_comb begin
        fault_n_o   = ~(ctl.alarm | (|stg) | (|stb));
        ov_flag_o   = ctl.ov.data;
        ov_oe_o     = ctl.ov.oe;
        uv_flag_o   = ctl.uv.data;
        uv_oe_o     = ctl.uv.oe;
        boost_en_o  = ctl.boost_en;
        vreg_en_o   = ctl.vreg_en;
        gate_kill_o = ctl.gate_kill;
    end

endmodule

// File: rtl/bfd_checker.sv
module bfd_checker #(
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           enable_i,
    input logic [NPH-1:0] gate_hi_i,
    input logic [NPH-1:0] gate_lo_i,
    input logic [NPH-1:0] hs_ovth_i,
    input logic [NPH-1:0] ls_ovth_i,
    input logic           drain_open_i,
    input logic           bat_ov_i,
    input logic           bat_uv_i,
    input logic           reg_uv_i,
    input logic           logic_uv_i,
    input logic           therm_i,
    input logic           fault_n_o,
    input logic           ov_flag_o,
    input logic           ov_oe_o,
    input logic           uv_flag_o,
    input logic           uv_oe_o,
    input logic           boost_en_o,
    input logic           vreg_en_o,
    input logic           gate_kill_o
);

    logic sup_any;
    assign sup_any = bat_ov_i | bat_uv_i | reg_uv_i | logic_uv_i | therm_i;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fault_n_o && boost_en_o && vreg_en_o && !gate_kill_o
                        && ov_oe_o && uv_oe_o && !ov_flag_o && !uv_flag_o));

    assert_short_gnd_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(enable_i && |(gate_hi_i & hs_ovth_i))) |-> !fault_n_o);

    assert_short_bat_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(enable_i && |(gate_lo_i & ls_ovth_i))) |-> !fault_n_o);

    assert_coast_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!enable_i && !sup_any)) |-> fault_n_o);

    assert_open_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(enable_i && drain_open_i)) |-> !fault_n_o);

    assert_supply_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sup_any)) |-> !fault_n_o);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(ov_flag_o && uv_flag_o));

    assert_float_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(therm_i || logic_uv_i)) |-> (!ov_oe_o && !uv_oe_o));

    assert_shutdown_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bat_uv_i || logic_uv_i || therm_i))
            |-> (gate_kill_o && !boost_en_o && !vreg_en_o));

    assert_ov_limit_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bat_ov_i && !bat_uv_i && !logic_uv_i && !therm_i))
            |-> (!boost_en_o && vreg_en_o && !gate_kill_o));

    assert_report_only_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!bat_ov_i && !bat_uv_i && !logic_uv_i && !therm_i))
            |-> (boost_en_o && vreg_en_o && !gate_kill_o));

    assert_no_latch_R12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!sup_any && !(enable_i && (drain_open_i
            || |(gate_hi_i & hs_ovth_i) || |(gate_lo_i & ls_ovth_i)))))
            |-> fault_n_o);

endmodule

bind bridge_fault_diag bfd_checker #(.NPH(NPH)) u_chk (.*);

// File: tb/bridge_fault_diag_test.sv
module bridge_fault_diag_test;

    localparam int NPH = 3;

    typedef struct packed {
        logic           en;
        logic [NPH-1:0] gh, gl, hs, ls;
        logic           open, bov, buv, ruv, luv, thm;
    } stim_t;

    typedef struct packed {
        logic fault_n, ovd, ovoe, uvd, uvoe, boost, vreg, kill;
    } exp_t;

    typedef struct {
        exp_t  e;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic           enable_i = 1'b0;
    logic [NPH-1:0] gate_hi_i = '0, gate_lo_i = '0, hs_ovth_i = '0, ls_ovth_i = '0;
    logic drain_open_i = 1'b0, bat_ov_i = 1'b0, bat_uv_i = 1'b0;
    logic reg_uv_i = 1'b0, logic_uv_i = 1'b0, therm_i = 1'b0;
    logic fault_n_o, ov_flag_o, ov_oe_o, uv_flag_o, uv_oe_o;
    logic boost_en_o, vreg_en_o, gate_kill_o;

    int tests = 0;
    int fails = 0;
    item_t q[$];

    always #4 clk = ~clk;

    bridge_fault_diag #(.NPH(NPH)) uut (.*);

    function automatic exp_t model(stim_t s);
        exp_t e;
        logic gnd, bat, sup, flt, shut;
        gnd  = s.en & ((|(s.gh & s.hs)) | s.open);
        bat  = s.en & (|(s.gl & s.ls));
        sup  = s.bov | s.buv | s.ruv | s.luv | s.thm;
        flt  = s.thm | s.luv;
        shut = s.buv | s.luv | s.thm;
        e.fault_n = ~(gnd | bat | sup);
        e.ovoe    = ~flt;
        e.uvoe    = ~flt;
        e.ovd     = flt ? 1'b0 : (s.bov & ~s.buv);
        e.uvd     = flt ? 1'b0 : s.buv;
        e.kill    = shut;
        e.vreg    = ~shut;
        e.boost   = ~(shut | s.bov);
        return e;
    endfunction

    function automatic exp_t observe();
        exp_t a;
        a = '{fault_n_o, ov_flag_o, ov_oe_o, uv_flag_o, uv_oe_o,
              boost_en_o, vreg_en_o, gate_kill_o};
        return a;
    endfunction

    task automatic compare(exp_t act, exp_t exp, string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (fault_n ovd ovoe uvd uvoe boost vreg kill)",
                     tag, act, exp);
        end
    endtask

    task automatic apply(stim_t s, string tag);
        item_t it;
        @(negedge clk);
        enable_i = s.en; gate_hi_i = s.gh; gate_lo_i = s.gl;
        hs_ovth_i = s.hs; ls_ovth_i = s.ls; drain_open_i = s.open;
        bat_ov_i = s.bov; bat_uv_i = s.buv; reg_uv_i = s.ruv;
        logic_uv_i = s.luv; therm_i = s.thm;
        it.e = model(s);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: one registered stage, so compare just after the next edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compare(observe(), it.e, it.tag);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        stim_t s;
        exp_t rexp;
        rexp = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
        // R1: faults driven while reset is held must not appear.
        bat_uv_i = 1'b1; therm_i = 1'b1; enable_i = 1'b1; gate_hi_i = '1; hs_ovth_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(observe(), rexp, "R1 reset state");
        bat_uv_i = 1'b0; therm_i = 1'b0; enable_i = 1'b0; gate_hi_i = '0; hs_ovth_i = '0;
        rst = 1'b0;
        @(posedge clk);
        #2;
        compare(observe(), rexp, "R1 first cycle after reset");

        s = '0;
        apply(s, "R11 idle");
        for (int p = 0; p < NPH; p++) begin
            s = '0; s.en = 1; s.gh[p] = 1; s.hs[p] = 1;
            apply(s, "R2 short to ground");
        end
        s = '0; s.en = 0; s.gh = '1; s.hs = '1;
        apply(s, "R4 ground short in coast");
        s = '0; s.en = 1; s.gl = 3'b010; s.hs = 3'b010;
        apply(s, "R4 high bit with only low gate on");
        for (int p = 0; p < NPH; p++) begin
            s = '0; s.en = 1; s.gl[p] = 1; s.ls[p] = 1;
            apply(s, "R3 short to battery R11");
        end
        s = '0; s.en = 1; s.gh = 3'b001; s.ls = 3'b001;
        apply(s, "R4 low bit with only high gate on");
        s = '0; s.en = 0; s.gl = '1; s.ls = '1;
        apply(s, "R4 battery short in coast");
        s = '0; s.en = 1; s.open = 1;
        apply(s, "R5 bridge open");
        s = '0; s.en = 0; s.open = 1;
        apply(s, "R5 bridge open in coast");
        s = '0; s.bov = 1;
        apply(s, "R6 R7 R10 overvoltage");
        s = '0; s.buv = 1;
        apply(s, "R6 R7 R9 undervoltage");
        s = '0; s.ruv = 1; s.en = 1;
        apply(s, "R6 R11 regulator undervoltage");
        s = '0; s.luv = 1;
        apply(s, "R6 R8 R9 logic undervoltage");
        s = '0; s.thm = 1; s.bov = 1;
        apply(s, "R8 R9 thermal with overvoltage");
        s = '0; s.bov = 1; s.buv = 1;
        apply(s, "R7 both battery comparators");
        s = '0; s.en = 1; s.gh = 3'b100; s.hs = 3'b100;
        apply(s, "R2 phase 2 again");
        s = '0; s.en = 1; s.gh = 3'b100;
        apply(s, "R12 clears next cycle");
        s = '0; s.thm = 1;
        apply(s, "R9 thermal");
        s = '0;
        apply(s, "R12 recover after thermal");

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule